// File: doc/BRIEF.md
# Serial Gain-Control Register with Deferred Apply

This block is the digital control front end of a programmable-gain amplifier. A host writes a 10-bit control word over a three-wire serial bus: a serial clock, a data line and an active-low enable. While enable is low, each rising serial-clock edge shifts one bit into a shift register, most significant bit first. The rising edge of enable copies the shift register into a holding register. From there a 5-bit gain/attenuation code and a 3-bit output-stage current code are split out.

The held codes do not reach the active outputs when they are latched. They are applied only on a rising edge of the transmit-enable input. Transmit enable is asynchronous to the system clock and passes through a synchronizer first. A word written while transmit is on therefore waits until transmit has been switched off and on again. The settings are kept across a transmit-off period, so a host does not need to reload them. Both amplifier stages are powered only while transmit is on and the active current code is not zero.

The serial lines are also sampled into the system clock domain. The whole block therefore runs on one clock.

Top module: `pga_ctrl`

## Requirements
- R1: After reset the gain code is 0 (minimum gain), the current code is 0, both stage enables are low and the format-error flag is low.
- R2: While enable is low, each rising serial-clock edge shifts one data bit into the word, most significant bit first. The rising edge of enable latches the last 10 bits shifted. Earlier bits of a longer burst are dropped.
- R3: In the latched word, bits 6 down to 2 form the gain code (00000 is minimum gain, 11111 is maximum gain). Bits 9 down to 7 form the current code (111 is maximum current).
- R4: The gain and current outputs change only on a synchronized rising edge of transmit enable. At that edge they take the held codes. A word latched while transmit is on leaves the outputs unchanged until transmit has gone low and then high again.
- R5: The held and active codes are kept while transmit is off. Switching transmit off and back on without a new word restores the same codes.
- R6: Both stage enables are high exactly when the synchronized transmit enable is high and the active current code is non-zero. A current code of 000 turns both stages off.
- R7: The format-error flag pulses high for exactly one cycle when a word is latched with bit 0 equal to 0 or bit 1 equal to 1. A word with bit 0 = 1 and bit 1 = 0 raises no pulse.
- R8: Rising serial-clock edges that arrive while enable is high do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bus clock (asynchronous) |
| ser_dat_i | input | 1 | Serial bus data |
| ser_en_ni | input | 1 | Serial bus enable, active low (asynchronous) |
| tx_en_i | input | 1 | Transmit enable, high = on (asynchronous) |
| gain_code_o | output | 5 | Active gain/attenuation code |
| cur_code_o | output | 3 | Active output-stage current code |
| stage_in_on_o | output | 1 | Input gain stage power-on |
| stage_out_on_o | output | 1 | Output gain stage power-on |
| fmt_err_o | output | 1 | One-cycle pulse on a latched word with a bad format |

## Verification
The bench targets a word loaded while transmit is on. If the design applied the latch directly to the outputs, the gain would jump before transmit was cycled. The bench also switches transmit off and on without a reload, which exposes a design that clears the settings while transmit is off. A current code of zero is applied with transmit on, and a design that gated the stages on transmit alone would leave them powered. The remaining checks cover wrong field slicing or bit order, serial-clock edges that leak through while enable is high, bursts longer than 10 bits, and both kinds of format violation.

// File: rtl/pga_pkg.sv
package pga_pkg;
  localparam int unsigned WORD_W  = 10;
  localparam int unsigned GAIN_W  = 5;
  localparam int unsigned CUR_W   = 3;
  localparam int unsigned GAIN_LSB = 2;
  localparam int unsigned CUR_LSB  = GAIN_LSB + GAIN_W;
  localparam int unsigned ONE_BIT  = 0;
  localparam int unsigned ZERO_BIT = 1;

  typedef struct packed {
    logic [CUR_W-1:0]  cur;
    logic [GAIN_W-1:0] gain;
  } setting_t;

  function automatic logic word_bad(input logic [WORD_W-1:0] w);
    return !w[ONE_BIT] || w[ZERO_BIT];
  endfunction
endpackage

// File: rtl/pga_sync.sv
module pga_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [W-1:0]       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
      prev_q  <= lvl_o;
    end
  end

  assign lvl_o = chain_q[CHAIN_W-1 -: W];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise_o[b] = lvl_o[b] & ~prev_q[b];
  end
endmodule

// File: rtl/pga_shift.sv
module pga_shift
  import pga_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              dat_i,
  input  logic              en_lvl_i,
  input  logic              en_rise_i,
  output logic [WORD_W-1:0] word_o,
  output logic              lat_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (sck_rise_i && !en_lvl_i) sh_q <= {sh_q[WORD_W-2:0], dat_i};
  end

  assign word_o = sh_q;
  assign lat_o  = en_rise_i;
endmodule

// File: rtl/pga_apply.sv
module pga_apply
  import pga_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lat_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tx_lvl_i,
  input  logic              tx_rise_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [CUR_W-1:0]  cur_o,
  output logic              stage_in_o,
  output logic              stage_out_o,
  output logic              err_o
);
  setting_t held_q, act_q;
  logic     err_q;
  logic     pwr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      act_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= lat_i && word_bad(word_i);
      if (lat_i) begin
        held_q.cur  <= word_i[CUR_LSB +: CUR_W];
        held_q.gain <= word_i[GAIN_LSB +: GAIN_W];
      end
      // apply takes the value held before any same-cycle latch
      if (tx_rise_i) act_q <= held_q;
    end
  end

  assign pwr         = tx_lvl_i && (act_q.cur != '0);
  assign gain_o      = act_q.gain;
  assign cur_o       = act_q.cur;
  assign stage_in_o  = pwr;
  assign stage_out_o = pwr;
  assign err_o       = err_q;
endmodule

// File: rtl/pga_ctrl.sv
module pga_ctrl
  import pga_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_en_ni,
  input  logic              tx_en_i,
  output logic [GAIN_W-1:0] gain_code_o,
  output logic [CUR_W-1:0]  cur_code_o,
  output logic              stage_in_on_o,
  output logic              stage_out_on_o,
  output logic              fmt_err_o
);
  localparam int unsigned IN_W = 4;
  localparam int unsigned I_SCK = 0, I_DAT = 1, I_EN = 2, I_TX = 3;
  localparam logic [IN_W-1:0] IN_RST = 4'b0100; // enable idles high

  logic [IN_W-1:0]   raw, lvl, rise;
  logic [WORD_W-1:0] shreg;
  logic              lat;
  logic              tx_rise, tx_lvl, en_lvl;

  assign raw = {tx_en_i, ser_en_ni, ser_dat_i, ser_clk_i};

  pga_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw), .lvl_o(lvl), .rise_o(rise)
  );

  assign tx_rise = rise[I_TX];
  assign tx_lvl  = lvl[I_TX];
  assign en_lvl  = lvl[I_EN];

  pga_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_rise_i(rise[I_SCK]),
    .dat_i     (lvl[I_DAT]),
    .en_lvl_i  (en_lvl),
    .en_rise_i (rise[I_EN]),
    .word_o    (shreg),
    .lat_o     (lat)
  );

  pga_apply u_apply (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lat_i      (lat),
    .word_i     (shreg),
    .tx_lvl_i   (tx_lvl),
    .tx_rise_i  (tx_rise),
    .gain_o     (gain_code_o),
    .cur_o      (cur_code_o),
    .stage_in_o (stage_in_on_o),
    .stage_out_o(stage_out_on_o),
    .err_o      (fmt_err_o)
  );
endmodule

// File: rtl/pga_ctrl_chk.sv
module pga_ctrl_chk
  import pga_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [GAIN_W-1:0] gain_code_o,
  input logic [CUR_W-1:0]  cur_code_o,
  input logic              stage_in_on_o,
  input logic              stage_out_on_o,
  input logic              fmt_err_o,
  input logic              tx_rise,
  input logic              lat,
  input logic              en_lvl,
  input logic [WORD_W-1:0] shreg
);
  AST_HOLD_NO_TX_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_rise |=> ($stable(gain_code_o) && $stable(cur_code_o))); // R4

  AST_STAGE_NEEDS_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_in_on_o || stage_out_on_o) |-> (cur_code_o != '0)); // R6

  AST_STAGES_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_in_on_o == stage_out_on_o); // R6

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |=> !fmt_err_o); // R7

  AST_ERR_AFTER_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fmt_err_o) |-> $past(lat)); // R7

  AST_SHIFT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_lvl |=> $stable(shreg)); // R8
endmodule

bind pga_ctrl pga_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .gain_code_o   (gain_code_o),
  .cur_code_o    (cur_code_o),
  .stage_in_on_o (stage_in_on_o),
  .stage_out_on_o(stage_out_on_o),
  .fmt_err_o     (fmt_err_o),
  .tx_rise       (tx_rise),
  .lat           (lat),
  .en_lvl        (en_lvl),
  .shreg         (shreg)
);

// File: tb/pga_ctrl_bench.sv
`timescale 1ns/1ps
module pga_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdat = 1'b0, sen_n = 1'b1, tx = 1'b0;
  logic [4:0] gain;
  logic [2:0] cur;
  logic st_in, st_out, ferr;

  int checks = 0, errors = 0, err_pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pga_ctrl u_pga_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sck), .ser_dat_i(sdat),
    .ser_en_ni(sen_n), .tx_en_i(tx), .gain_code_o(gain), .cur_code_o(cur),
    .stage_in_on_o(st_in), .stage_out_on_o(st_out), .fmt_err_o(ferr)
  );

  // reference model: input history {tx,en_n,dat,sck}, oldest first
  logic [3:0] hist[$];
  logic [9:0] m_sh;
  int m_hg, m_hc, m_ag, m_ac;
  bit m_err, m_tx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{4'b0100, 4'b0100, 4'b0100, 4'b0100};
      m_sh = '0; m_hg = 0; m_hc = 0; m_ag = 0; m_ac = 0; m_err = 0; m_tx = 0;
    end else begin
      hist.push_back({tx, sen_n, sdat, sck});
      void'(hist.pop_front());
      if (hist[1][3] && !hist[0][3]) begin m_ag = m_hg; m_ac = m_hc; end
      m_err = 0;
      if (hist[1][2] && !hist[0][2]) begin
        m_hc = m_sh / 128;
        m_hg = (m_sh / 4) % 32;
        m_err = (m_sh[0] == 1'b0) || (m_sh[1] == 1'b1);
      end
      if (hist[1][0] && !hist[0][0] && !hist[1][2]) m_sh = {m_sh[8:0], hist[1][1]};
      m_tx = hist[2][3];
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 gain vs model", gain, m_ag);
      check("R4 cur vs model", cur, m_ac);
      check("R6 stage_in vs model", st_in, (m_tx && m_ac != 0));
      check("R6 stage_out vs model", st_out, (m_tx && m_ac != 0));
      check("R7 fmt_err vs model", ferr, m_err);
      if (ferr) err_pulses++;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] w, input int nbits);
    @(negedge clk); sen_n = 1'b0;
    wait_n(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdat = w[i];
      wait_n(4); sck = 1'b1;
      wait_n(4); sck = 1'b0;
    end
    wait_n(4); sen_n = 1'b1;
    wait_n(8);
  endtask

  task automatic cycle_tx();
    @(negedge clk); tx = 1'b0;
    wait_n(6); tx = 1'b1;
    wait_n(6);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0;
    wait_n(3); rst_n = 1'b1; wait_n(2);
    check("R1 reset gain", gain, 0);
    check("R1 reset cur", cur, 0);
    check("R1 reset stages", {st_in, st_out}, 0);
    check("R1 reset err", ferr, 0);

    // cur=101 gain=10011 fmt=01, tx off: no change yet
    send_bits(16'b1011001101, 10);
    check("R4 no apply while tx low", gain, 0);
    @(negedge clk); tx = 1'b1; wait_n(6);
    check("R3 gain field", gain, 19);
    check("R3 cur field", cur, 5);
    check("R6 stages on", {st_in, st_out}, 3);

    // cur=011 gain=00111 while tx on: deferred
    send_bits(16'b0110011101, 10);
    check("R4 deferred gain", gain, 19);
    check("R4 deferred cur", cur, 5);
    @(negedge clk); tx = 1'b0; wait_n(6);
    check("R6 stages off with tx low", {st_in, st_out}, 0);
    check("R5 active kept while tx low", gain, 19);
    tx = 1'b1; wait_n(6);
    check("R4 applied gain", gain, 7);
    check("R4 applied cur", cur, 3);

    cycle_tx();
    check("R5 retained gain", gain, 7);
    check("R5 retained cur", cur, 3);
    check("R5 stages back on", {st_in, st_out}, 3);

    // cur=000 gain=11111
    send_bits(16'b0001111101, 10);
    cycle_tx();
    check("R6 max gain code", gain, 31);
    check("R6 zero cur powers down", {st_in, st_out}, 0);

    // format checks
    p0 = err_pulses;
    send_bits(16'b1110000000, 10);
    check("R7 bit0 low flagged", err_pulses - p0, 1);
    p0 = err_pulses;
    send_bits(16'b1110000011, 10);
    check("R7 bit1 high flagged", err_pulses - p0, 1);
    p0 = err_pulses;
    send_bits(16'b1110000101, 10);
    check("R7 valid word quiet", err_pulses - p0, 0);

    // clocks with enable high are ignored; relatch the unchanged word
    sdat = 1'b0;
    for (int i = 0; i < 6; i++) begin
      wait_n(4); sck = 1'b1; wait_n(4); sck = 1'b0;
    end
    send_bits(16'h0, 0);
    cycle_tx();
    check("R8 ignored clocks gain", gain, 1);
    check("R8 ignored clocks cur", cur, 7);

    // 13-bit burst: only last 10 bits kept (leading 111 dropped)
    send_bits(16'b1110100101001, 13);
    cycle_tx();
    check("R2 long burst gain", gain, 10);
    check("R2 long burst cur", cur, 2);
    check("R2 long burst no err", ferr, 0);

    wait_n(4);
    finish_run();
  end
endmodule